// File: doc/BRIEF.md
# Multichannel reload timer

A register-mapped timer with a small number of independent down-counting channels. Each channel holds a reload value, a live count and a 16-bit control word. A shared free-running divider provides five count rates: the input clock divided by 4, 16, 64, 256 or 1024. The control word picks one rate per channel. While its run bit is set, a channel counts down once per selected tick. When it steps past zero, it reloads from its reload value and latches a sticky underflow flag.

Software writes the reload value and the count while a channel is stopped. The first count sets the delay to the first event. The reload value sets the period after that, so an all-ones reload gives the longest interval. One byte-wide start register holds a run bit for every channel. A control write acknowledges the flag and can also mask the channel's interrupt line.

The register port is a plain synchronous bus with byte address, write strobe, write data and combinational read data. Every access completes in one cycle with no back-pressure, so the port has no valid/ready handshake.

Top module: `mc_reload_timer`

## Requirements
- R1: After reset every count and reload register reads 0xFFFFFFFF. Every control word reads 0, the start register reads 0, and all interrupt lines are low.
- R2: In the default layout the start register sits at byte offset 4. Channel n's reload, count and control registers sit at 8+12n, 12+12n and 16+12n. With the compact layout selected, the start register is at 2 and channel n begins at 4+12n. Unmapped addresses read 0.
- R3: Start register bit n runs channel n (1) or stops it (0). Bits for channels that do not exist are dropped on write and read as 0.
- R4: A running channel decrements by one on each tick of its selected rate. Control bits [2:0] select the rate: code 0 is /4, 1 is /16, 2 is /64, 3 is /256 and 4 is /1024. The dividers run freely from reset, so a /D tick falls on the D-th, 2D-th and later clock edges after reset is released.
- R5: Control codes 5, 6 and 7 give no ticks, so the count holds.
- R6: On a tick with the count at zero, the count loads the reload value and the underflow flag (control bit 8) is set.
- R7: The underflow flag stays set until a control write with bit 8 at 0 clears it. A control write with bit 8 at 1 leaves the flag unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: Channel n's interrupt line is high exactly while its underflow flag and its interrupt enable (control bit 5) are both 1.
- R9: A stopped channel holds its count and its flag.
- R10: The count and reload registers take any written value, and a count write overrides counting in that cycle. An underflow reload uses the reload value held before a same-cycle reload write.
- R11: A control read returns the rate code in bits [2:0], the enable in bit 5 and the flag in bit 8. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, applied at the rising edge |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| irq | output | NUM_CH | Per-channel interrupt, level |

## Verification
The main instance uses three channels, 32-bit counters and the default layout. A second instance uses two channels with the compact layout, which checks that the offset generate picks the other address map. Small reload and count values make underflow happen within tens of cycles at /4 and /16 and within about two thousand cycles at /1024. The reference model follows every register of every channel on every cycle, including the reserved rate codes and writes that land in the same cycle as a tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NTAP       = 5;
  localparam int SEL_W      = 3;
  localparam int FLAG_BIT   = 8;
  localparam int IE_BIT     = 5;
  localparam int CTL_W      = 16;
  localparam int START_W    = 8;
  localparam int REG_STRIDE = 12;

  typedef struct packed {
    logic             flag;
    logic             ie;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  function automatic logic [CTL_W-1:0] ctl_image(input ctl_t c);
    logic [CTL_W-1:0] img;
    img              = '0;
    img[SEL_W-1:0]   = c.sel;
    img[IE_BIT]      = c.ie;
    img[FLAG_BIT]    = c.flag;
    return img;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int NTAP_P = tmr_pkg::NTAP
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [NTAP_P-1:0] tick
);
  localparam int PW = 2 * NTAP_P;

  logic [PW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // tap k divides by 4^(k+1): all low 2k+2 bits set
  for (genvar k = 0; k < NTAP_P; k++) begin : g_tap
    assign tick[k] = &div_q[2*k+1:0];
    if (k > 0) begin : g_nest
      AST_TAP_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        tick[k] |-> tick[k-1]); // R4
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NTAP_P = NTAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [NTAP_P-1:0] tick,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              cor_we,
  input  logic              cnt_we,
  input  logic              ctl_we,
  output logic [CNT_W-1:0]  cor_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CTL_W-1:0]  ctl_img,
  output logic              irq
);
  localparam int NSEL = 2 ** SEL_W;

  ctl_t            ctl_q;
  logic [NSEL-1:0] tick_ext;
  logic            step;
  logic            at_zero;
  logic            uf;

  // codes beyond the implemented taps see a constant zero
  assign tick_ext = NSEL'(tick);
  assign step     = run && tick_ext[ctl_q.sel];
  assign at_zero  = (cnt_q == '0);
  assign uf       = step && at_zero && !cnt_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cor_q <= '1;
      cnt_q <= '1;
      ctl_q <= '0;
    end else begin
      if (cor_we) cor_q <= wdata;
      if (cnt_we)    cnt_q <= wdata;
      else if (step) cnt_q <= at_zero ? cor_q : cnt_q - 1'b1;
      if (ctl_we) begin
        ctl_q.sel  <= wdata[SEL_W-1:0];
        ctl_q.ie   <= wdata[IE_BIT];
        ctl_q.flag <= (ctl_q.flag & wdata[FLAG_BIT]) | uf;
      end else if (uf) begin
        ctl_q.flag <= 1'b1;
      end
    end
  end

  assign ctl_img = ctl_image(ctl_q);
  assign irq     = ctl_q.flag & ctl_q.ie;

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    step && !at_zero && !cnt_we |=> cnt_q == $past(cnt_q) - 1'b1); // R4
  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.sel > 3'd4) && !cnt_we |=> $stable(cnt_q)); // R5
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    step && at_zero && !cnt_we |=> (cnt_q == $past(cor_q)) && ctl_q.flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.flag && !ctl_we |=> ctl_q.flag); // R7
  AST_STOP_HOLD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_we |=> $stable(cnt_q)); // R9
  AST_STOP_HOLD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !ctl_we |=> $stable(ctl_q.flag)); // R9
  AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(wdata)); // R10
endmodule

// File: rtl/mc_reload_timer.sv
module mc_reload_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8,
  parameter bit COMPACT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int START_OFS = COMPACT ? 2 : 4;
  localparam int GRP_BASE  = COMPACT ? 4 : 8;
  localparam int OFS_CNT   = 4;
  localparam int OFS_CTL   = 8;

  logic [NUM_CH-1:0] run_q;
  logic [NTAP-1:0]   tick;
  logic              start_hit;

  logic [CNT_W-1:0]  cor_v [NUM_CH];
  logic [CNT_W-1:0]  cnt_v [NUM_CH];
  logic [CTL_W-1:0]  ctl_v [NUM_CH];

  assign start_hit = (bus_addr == ADDR_W'(START_OFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_q <= '0;
    else if (bus_we && start_hit) run_q <= bus_wdata[NUM_CH-1:0];
  end

  tmr_prescaler #(.NTAP_P(NTAP)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int GB = GRP_BASE + REG_STRIDE * i;
    logic hit_cor, hit_cnt, hit_ctl;

    assign hit_cor = (bus_addr == ADDR_W'(GB));
    assign hit_cnt = (bus_addr == ADDR_W'(GB + OFS_CNT));
    assign hit_ctl = (bus_addr == ADDR_W'(GB + OFS_CTL));

    tmr_channel #(.CNT_W(CNT_W), .NTAP_P(NTAP)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q[i]),
      .tick   (tick),
      .wdata  (bus_wdata),
      .cor_we (bus_we && hit_cor),
      .cnt_we (bus_we && hit_cnt),
      .ctl_we (bus_we && hit_ctl),
      .cor_q  (cor_v[i]),
      .cnt_q  (cnt_v[i]),
      .ctl_img(ctl_v[i]),
      .irq    (irq[i])
    );

    AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> ctl_v[i][FLAG_BIT] && ctl_v[i][IE_BIT]); // R8
  end

  always_comb begin
    bus_rdata = '0;
    if (start_hit) bus_rdata = CNT_W'(run_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(GRP_BASE + REG_STRIDE * i))           bus_rdata = cor_v[i];
      if (bus_addr == ADDR_W'(GRP_BASE + REG_STRIDE * i + OFS_CNT)) bus_rdata = cnt_v[i];
      if (bus_addr == ADDR_W'(GRP_BASE + REG_STRIDE * i + OFS_CTL)) bus_rdata = CNT_W'(ctl_v[i]);
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && start_hit |=> run_q == $past(bus_wdata[NUM_CH-1:0])); // R3
endmodule

// File: tb/sim_mc_reload_timer.sv
`timescale 1ns/1ps
module sim_mc_reload_timer;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;

  logic [7:0]  b1_addr = '0;
  logic        b1_we = 1'b0;
  logic [31:0] b1_wdata = '0;
  logic [31:0] b1_rdata;
  logic [1:0]  b1_irq;

  int nchk = 0;
  int nfail = 0;
  bit live = 1'b0;
  int scan_i = 0;

  always #2.5 clk = ~clk;

  mc_reload_timer #(.NUM_CH(NCH), .CNT_W(32), .ADDR_W(8), .COMPACT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  mc_reload_timer #(.NUM_CH(2), .CNT_W(32), .ADDR_W(8), .COMPACT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(b1_addr), .bus_we(b1_we),
    .bus_wdata(b1_wdata), .bus_rdata(b1_rdata), .irq(b1_irq));

  // behavioural reference model of u0
  logic [31:0]    m_cor [NCH];
  logic [31:0]    m_cnt [NCH];
  bit             m_flag [NCH];
  bit             m_ie [NCH];
  bit [2:0]       m_sel [NCH];
  bit [NCH-1:0]   m_run;
  int unsigned    pc;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_cor[i] = '1; m_cnt[i] = '1; m_flag[i] = 0; m_ie[i] = 0; m_sel[i] = 0;
      end
      m_run = '0;
      pc = 0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        automatic int base = 8 + 12 * i;
        automatic logic [31:0] ncnt = m_cnt[i];
        automatic bit uf = 0;
        automatic int dv;
        if (bus_we && bus_addr == 8'(base + 4)) ncnt = bus_wdata;
        else if (m_run[i] && m_sel[i] <= 3'd4) begin
          dv = 1 << (2 * m_sel[i] + 2);
          if (pc % dv == dv - 1) begin
            if (m_cnt[i] == 0) begin ncnt = m_cor[i]; uf = 1; end
            else ncnt = m_cnt[i] - 1;
          end
        end
        if (bus_we && bus_addr == 8'(base + 8)) begin
          m_flag[i] = (m_flag[i] & bus_wdata[8]) | uf;
          m_ie[i] = bus_wdata[5];
          m_sel[i] = bus_wdata[2:0];
        end else if (uf) m_flag[i] = 1;
        if (bus_we && bus_addr == 8'(base)) m_cor[i] = bus_wdata;
        m_cnt[i] = ncnt;
      end
      if (bus_we && bus_addr == 8'd4) m_run = bus_wdata[NCH-1:0];
      pc++;
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'd4) return 32'(m_run);
    for (int i = 0; i < NCH; i++) begin
      if (a == 8'(8 + 12 * i)) return m_cor[i];
      if (a == 8'(12 + 12 * i)) return m_cnt[i];
      if (a == 8'(16 + 12 * i))
        return {23'd0, m_flag[i], 2'b00, m_ie[i], 2'b00, m_sel[i]};
    end
    return 32'd0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'd4) return "R3";
    if (a >= 8'd8 && a < 8'(8 + 12 * NCH)) begin
      case ((a - 8) % 12)
        0: return "R10";
        4: return "R4";
        8: return "R7";
        default: return "R2";
      endcase
    end
    return "R2";
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (live) begin
      #1;
      chk(tag_of(bus_addr), "readback", bus_rdata, model_read(bus_addr));
      for (int i = 0; i < NCH; i++)
        chk("R8", "irq", 32'(irq[i]), 32'(m_flag[i] & m_ie[i]));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_we = 1'b0;
      bus_addr = 8'(4 + 4 * scan_i);
      scan_i = (scan_i + 1) % 11;
    end
  endtask

  task automatic chk_now(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; #1;
    chk(tag, "directed", bus_rdata, exp);
  endtask

  task automatic chk_at(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_we = 1'b0; chk_now(a, exp, tag);
  endtask

  task automatic wr1(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); b1_addr = a; b1_we = 1'b1; b1_wdata = d;
    @(negedge clk); b1_we = 1'b0;
  endtask

  task automatic rd1(input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); b1_addr = a; #1;
    chk("R2", "compact layout", b1_rdata, exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;

    // R1 reset state
    chk_at(8'd4, 32'd0, "R1");
    chk_at(8'd8, 32'hFFFF_FFFF, "R1");
    chk_at(8'd12, 32'hFFFF_FFFF, "R1");
    chk_at(8'd16, 32'd0, "R1");
    chk("R1", "irq after reset", 32'(irq), 32'd0);

    // R2 compact layout on u1: start at 2, channel n at 4+12n
    wr1(8'd16, 32'h0000_1234);
    wr1(8'd2, 32'h0000_00FF);
    rd1(8'd16, 32'h0000_1234);
    rd1(8'd2, 32'h0000_0003);
    rd1(8'd4, 32'hFFFF_FFFF);
    rd1(8'd24, 32'd0);
    chk_at(8'd44, 32'd0, "R2");

    // R4 R6 R8: channel 0 at /4, short period, interrupt enabled
    wr(8'd8, 32'd5);
    wr(8'd12, 32'd3);
    wr(8'd16, 32'h0000_0020);
    wr(8'd4, 32'h0000_0001);
    idle(40);
    chk_at(8'd16, 32'h0000_0120, "R6");
    chk("R8", "irq0 high with flag and enable", 32'(irq[0]), 32'd1);
    // R7 writing 1 to the flag keeps it
    wr(8'd16, 32'h0000_0120);
    chk_now(8'd16, model_read(8'd16), "R7");
    chk("R7", "flag kept by write of 1", 32'(bus_rdata[8]), 32'd1);
    wr(8'd16, 32'h0000_0020);
    chk_now(8'd16, model_read(8'd16), "R7");
    idle(30);
    // R8 masking the enable drops the line
    wr(8'd16, 32'h0000_0000);
    chk_now(8'd16, model_read(8'd16), "R11");
    chk("R8", "irq0 masked", 32'(irq[0]), 32'd0);

    // R3 R5: channel 1 at /16, channel 2 on a reserved code
    wr(8'd20, 32'd2);
    wr(8'd24, 32'd0);
    wr(8'd28, 32'h0000_0021);
    wr(8'd36, 32'd7);
    wr(8'd40, 32'h0000_0005);
    wr(8'd4, 32'h0000_00FF);
    chk_now(8'd4, 32'h0000_0007, "R3");
    idle(200);
    chk_at(8'd36, 32'd7, "R5");
    wr(8'd40, 32'h0000_0007);
    idle(100);
    chk_at(8'd36, 32'd7, "R5");

    // R10 count write while running lands exactly
    wr(8'd24, 32'd100);
    chk_now(8'd24, 32'd100, "R10");
    wr(8'd20, 32'd9);
    idle(120);

    // R9 stop channel 0: count and flag hold
    wr(8'd4, 32'h0000_0006);
    chk_at(8'd12, model_read(8'd12), "R9");
    held = bus_rdata;
    idle(60);
    chk_at(8'd12, held, "R9");

    // R4 /1024 on channel 2
    wr(8'd32, 32'd1);
    wr(8'd36, 32'd1);
    wr(8'd40, 32'h0000_0024);
    idle(4200);
    chk_at(8'd40, model_read(8'd40), "R4");
    chk("R6", "flag after /1024 underflow", 32'(bus_rdata[8]), 32'd1);
    chk("R8", "irq2 after /1024 underflow", 32'(irq[2]), 32'd1);

    idle(5);
    live = 1'b0;
    finish_run();
  end
endmodule